// File: doc/BRIEF.md
# Redundant Store Verification Buffer

This block sits between a pair of redundant threads and memory. The leading thread commits stores into it. Each store carries an address and data. The block holds these stores and never writes them to memory straight away. The trailing thread runs behind the leading one by some slack. It sends its own copy of each store to the same block rather than to memory. The block matches trailing copies strictly in program order against the oldest leading store that is still unchecked. A store becomes eligible for memory only when both its address and its data agree with the trailing copy.

Checked stores drain in order through a single valid/ready memory write port, at most one per cycle. If the two copies disagree, or if a trailing store arrives when no unchecked leading store is waiting, the block raises a sticky error with a kind code. It then freezes: no more drains, no more enqueues, and no more trailing matches. This lasts until an external clear empties the buffer. Recovery after an error is left to the surrounding logic, which restarts from the trailing thread's checked state.

Top module: `rsv_store_buffer`

## Requirements
- R1: After reset the block shows `lead_ready`=1, `mem_valid`=0, `err_flag`=0, `err_kind`=2'b00 and `buf_empty`=1.
- R2: A leading store is taken on a cycle with `lead_valid` and `lead_ready` both high. It is never offered on the memory port before its trailing copy has been checked, so `mem_valid` stays 0 while only unchecked stores are held.
- R3: With DEPTH stores held, counting both checked and unchecked ones, `lead_ready` is 0 and a leading store offered then is dropped and never reaches memory.
- R4: A trailing store whose address and data both equal those of the oldest unchecked leading store marks that store checked. The store appears on `mem_addr`/`mem_data` with `mem_valid`=1 in the cycle after the trailing store is taken, provided it is at the head.
- R5: Checked stores leave in the order the leading thread committed them, one per cycle while `mem_ready` is 1.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, the offered store stays on the port unchanged.
- R7: A trailing store that differs from the oldest unchecked store in address or in data sets `err_flag`=1 with `err_kind`=2'b01 in the next cycle, and that store is not released.
- R8: A trailing store taken when no unchecked leading store is held sets `err_flag`=1 with `err_kind`=2'b10 in the next cycle. This covers both an empty buffer and a buffer whose entries are all checked.
- R9: While `err_flag` is 1, `mem_valid` and `lead_ready` are 0, even if checked stores remain. Further trailing stores are ignored, and `err_kind` keeps the code of the first error.
- R10: A cycle with `clr`=1 takes priority over every other input. It empties the buffer and clears the error, so that the next cycle shows the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear: empties the buffer and drops the error |
| lead_valid | input | 1 | Leading store offered |
| lead_ready | output | 1 | Buffer can take a leading store |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| trail_valid | input | 1 | Trailing store copy offered (always taken) |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| mem_valid | output | 1 | Checked store offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| buf_empty | output | 1 | No store held |
| err_flag | output | 1 | Sticky disagreement or underflow error |
| err_kind | output | 2 | 2'b01 mismatch, 2'b10 trailing underflow, 2'b00 none |

## Verification
The hardest state to reach from the ports is one where the buffer holds checked stores still waiting for memory while an error freezes them. Reaching it needs memory back-pressure, a matching trailing store and then a mismatching one, all in sequence. The bench holds `mem_ready` low, matches the first of two stores, and corrupts only the data of the second. It then watches the held store disappear from the port. The underflow case where every held store is already checked is reached the same way, by holding memory back and sending one trailing store too many. A full buffer is filled and overfilled before any store is checked, so that a dropped extra store would show up in the drain order.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      ERR_NONE      = 2'b00,
      ERR_MISMATCH  = 2'b01,
      ERR_UNDERFLOW = 2'b10
   } err_kind_e;

endpackage

// File: rtl/rsv_ring.sv
// Circular store holder with three pointers: tail (next free slot),
// check (oldest unchecked store) and head (oldest checked store).
module rsv_ring #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int ENT_W = ADDR_W + DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [ENT_W-1:0] push_ent,
   input  logic             chk_adv,
   input  logic             pop,
   output logic [ENT_W-1:0] head_ent,
   output logic [ENT_W-1:0] chk_ent,
   output logic [CNT_W-1:0] n_tot,
   output logic [CNT_W-1:0] n_unchk
);

   localparam bit             IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rsv_ring: DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rsv_ring: ADDR_W and DATA_W must be positive");
   end

   logic [ENT_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] tail_q, chk_q, head_q;
   logic [PTR_W-1:0] tail_nx, chk_nx, head_nx;
   logic [CNT_W-1:0] n_tot_q, n_unchk_q;

   // Pointer advance: free wrap for power-of-two depths, explicit wrap otherwise.
   if (IS_POW2) begin : g_wrap_free
      assign tail_nx = tail_q + PTR_W'(1);
      assign chk_nx  = chk_q  + PTR_W'(1);
      assign head_nx = head_q + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign tail_nx = (tail_q == LAST) ? '0 : tail_q + PTR_W'(1);
      assign chk_nx  = (chk_q  == LAST) ? '0 : chk_q  + PTR_W'(1);
      assign head_nx = (head_q == LAST) ? '0 : head_q + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (push && !clr) begin
         slot_q[tail_q] <= push_ent;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         tail_q    <= '0;
         chk_q     <= '0;
         head_q    <= '0;
         n_tot_q   <= '0;
         n_unchk_q <= '0;
      end else begin
         if (push)    tail_q <= tail_nx;
         if (chk_adv) chk_q  <= chk_nx;
         if (pop)     head_q <= head_nx;
         n_tot_q   <= n_tot_q   + CNT_W'(push) - CNT_W'(pop);
         n_unchk_q <= n_unchk_q + CNT_W'(push) - CNT_W'(chk_adv);
      end
   end

   assign head_ent = slot_q[head_q];
   assign chk_ent  = slot_q[chk_q];
   assign n_tot    = n_tot_q;
   assign n_unchk  = n_unchk_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
      push |-> (n_tot_q < CNT_W'(DEPTH))); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (n_tot_q <= CNT_W'(DEPTH)) && (n_unchk_q <= n_tot_q)); // R3
   AST_MATCH_ADV: assert property (@(posedge clk) disable iff (!rst_n || clr)
      chk_adv |=> (n_unchk_q == $past(n_unchk_q) + CNT_W'($past(push)) - CNT_W'(1))); // R4
   AST_POP_HAS_CHECKED: assert property (@(posedge clk) disable iff (!rst_n || clr)
      pop |-> (n_tot_q != n_unchk_q)); // R2

endmodule

// File: rtl/rsv_check.sv
// Compares a trailing store copy with the oldest unchecked leading store.
module rsv_check #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4,
   localparam int ENT_W = ADDR_W + DATA_W
) (
   input  logic             trail_valid,
   input  logic [ENT_W-1:0] trail_ent,
   input  logic [ENT_W-1:0] chk_ent,
   input  logic [CNT_W-1:0] n_unchk,
   input  logic             frozen,
   output logic             chk_adv,
   output logic             set_mis,
   output logic             set_und
);

   logic active, have_unchk, addr_eq, data_eq;

   assign active     = trail_valid && !frozen;
   assign have_unchk = (n_unchk != '0);
   assign addr_eq    = (trail_ent[ENT_W-1:DATA_W] == chk_ent[ENT_W-1:DATA_W]);
   assign data_eq    = (trail_ent[DATA_W-1:0]     == chk_ent[DATA_W-1:0]);

   always_comb begin
      chk_adv = 1'b0;
      set_mis = 1'b0;
      set_und = 1'b0;
      if (active) begin
         if (!have_unchk)            set_und = 1'b1;
         else if (addr_eq && data_eq) chk_adv = 1'b1;
         else                        set_mis = 1'b1;
      end
   end

endmodule

// File: rtl/rsv_err.sv
// Sticky error register that keeps the first error kind until clear.
module rsv_err
   import rsv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      set_mis,
   input  logic      set_und,
   output logic      err_flag,
   output err_kind_e err_kind
);

   logic      err_q;
   err_kind_e kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         err_q  <= 1'b0;
         kind_q <= ERR_NONE;
      end else if (!err_q) begin
         if (set_mis) begin
            err_q  <= 1'b1;
            kind_q <= ERR_MISMATCH;
         end else if (set_und) begin
            err_q  <= 1'b1;
            kind_q <= ERR_UNDERFLOW;
         end
      end
   end

   assign err_flag = err_q;
   assign err_kind = kind_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr) |=> (err_q && $stable(kind_q))); // R9
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!err_q && kind_q == ERR_NONE)); // R10

endmodule

// File: rtl/rsv_store_buffer.sv
module rsv_store_buffer #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              lead_valid,
   output logic              lead_ready,
   input  logic [ADDR_W-1:0] lead_addr,
   input  logic [DATA_W-1:0] lead_data,
   input  logic              trail_valid,
   input  logic [ADDR_W-1:0] trail_addr,
   input  logic [DATA_W-1:0] trail_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              buf_empty,
   output logic              err_flag,
   output logic [1:0]        err_kind
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int ENT_W = ADDR_W + DATA_W;

   logic [ENT_W-1:0] head_ent, chk_ent;
   logic [CNT_W-1:0] n_tot, n_unchk;
   logic             push, pop, chk_adv, set_mis, set_und, err_w;
   rsv_pkg::err_kind_e kind_w;

   assign lead_ready = (n_tot != CNT_W'(DEPTH)) && !err_w;
   assign push       = lead_valid && lead_ready;
   assign mem_valid  = (n_tot != n_unchk) && !err_w;
   assign pop        = mem_valid && mem_ready;

   rsv_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .push     (push),
      .push_ent ({lead_addr, lead_data}),
      .chk_adv  (chk_adv),
      .pop      (pop),
      .head_ent (head_ent),
      .chk_ent  (chk_ent),
      .n_tot    (n_tot),
      .n_unchk  (n_unchk)
   );

   rsv_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) check_i (
      .trail_valid (trail_valid),
      .trail_ent   ({trail_addr, trail_data}),
      .chk_ent     (chk_ent),
      .n_unchk     (n_unchk),
      .frozen      (err_w),
      .chk_adv     (chk_adv),
      .set_mis     (set_mis),
      .set_und     (set_und)
   );

   rsv_err err_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .set_mis  (set_mis),
      .set_und  (set_und),
      .err_flag (err_w),
      .err_kind (kind_w)
   );

   assign mem_addr  = head_ent[ENT_W-1:DATA_W];
   assign mem_data  = head_ent[DATA_W-1:0];
   assign buf_empty = (n_tot == '0);
   assign err_flag  = err_w;
   assign err_kind  = kind_w;

   AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (mem_valid && !mem_ready && !set_mis && !set_und) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R6
   AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n || clr)
      err_flag |=> $stable(n_tot) && $stable(n_unchk)); // R9
   AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (trail_valid && n_unchk == '0 && !err_flag) |=> (err_flag && err_kind == 2'b10)); // R8
   AST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (trail_valid && n_unchk != '0 && !err_flag && !chk_adv) |=>
      (err_flag && err_kind == 2'b01)); // R7

endmodule

// File: tb/rsv_store_buffer_tb_top.sv
module rsv_store_buffer_tb_top;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int DP = 8;

   logic          clk = 1'b0;
   logic          rst_n, clr;
   logic          lead_valid, lead_ready;
   logic [AW-1:0] lead_addr;
   logic [DW-1:0] lead_data;
   logic          trail_valid;
   logic [AW-1:0] trail_addr;
   logic [DW-1:0] trail_data;
   logic          mem_valid, mem_ready;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic          buf_empty, err_flag;
   logic [1:0]    err_kind;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rsv_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .lead_valid(lead_valid), .lead_ready(lead_ready),
      .lead_addr(lead_addr), .lead_data(lead_data),
      .trail_valid(trail_valid), .trail_addr(trail_addr), .trail_data(trail_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data),
      .buf_empty(buf_empty), .err_flag(err_flag), .err_kind(err_kind)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic lead_put(input logic [AW-1:0] a, input logic [DW-1:0] d);
      lead_valid = 1'b1; lead_addr = a; lead_data = d;
      tick();
      lead_valid = 1'b0;
   endtask

   task automatic trail_put(input logic [AW-1:0] a, input logic [DW-1:0] d);
      trail_valid = 1'b1; trail_addr = a; trail_data = d;
      tick();
      trail_valid = 1'b0;
   endtask

   task automatic do_clear;
      clr = 1'b1;
      tick();
      clr = 1'b0;
   endtask

   function automatic logic [AW-1:0] ad(input int i);
      return AW'(16'h1000 + i * 4);
   endfunction
   function automatic logic [DW-1:0] dt(input int i);
      return DW'(32'hA5000000 + i * 7);
   endfunction

   task automatic t_reset_state;
      chk(lead_ready == 1'b1, "R1 lead_ready", 64'(lead_ready), 1);
      chk(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 0);
      chk(err_flag == 1'b0, "R1 err_flag", 64'(err_flag), 0);
      chk(err_kind == 2'b00, "R1 err_kind", 64'(err_kind), 0);
      chk(buf_empty == 1'b1, "R1 buf_empty", 64'(buf_empty), 1);
   endtask

   task automatic t_hold_then_drain;
      mem_ready = 1'b0;
      lead_put(ad(0), dt(0));
      lead_put(ad(1), dt(1));
      chk(mem_valid == 1'b0, "R2 unchecked held back", 64'(mem_valid), 0);
      chk(buf_empty == 1'b0, "R2 stores held", 64'(buf_empty), 0);
      trail_put(ad(0), dt(0));
      chk(mem_valid == 1'b1, "R4 valid after match", 64'(mem_valid), 1);
      chk(mem_addr == ad(0), "R4 addr after match", 64'(mem_addr), 64'(ad(0)));
      chk(mem_data == dt(0), "R4 data after match", 64'(mem_data), 64'(dt(0)));
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(mem_valid == 1'b1 && mem_addr == ad(0) && mem_data == dt(0),
             "R6 head held under back-pressure", 64'(mem_addr), 64'(ad(0)));
      end
      trail_put(ad(1), dt(1));
      mem_ready = 1'b1;
      for (int k = 0; k < 2; k++) begin
         chk(mem_valid == 1'b1 && mem_addr == ad(k) && mem_data == dt(k),
             "R5 drain order", 64'(mem_addr), 64'(ad(k)));
         tick();
      end
      chk(mem_valid == 1'b0, "R5 nothing left", 64'(mem_valid), 0);
      chk(buf_empty == 1'b1, "R5 empty after drain", 64'(buf_empty), 1);
      mem_ready = 1'b0;
   endtask

   task automatic t_full;
      mem_ready = 1'b0;
      for (int k = 0; k < DP; k++) lead_put(ad(10 + k), dt(10 + k));
      chk(lead_ready == 1'b0, "R3 ready low when full", 64'(lead_ready), 0);
      lead_put(ad(99), dt(99));
      for (int k = 0; k < DP; k++) trail_put(ad(10 + k), dt(10 + k));
      chk(lead_ready == 1'b0, "R3 full of checked stores", 64'(lead_ready), 0);
      mem_ready = 1'b1;
      for (int k = 0; k < DP; k++) begin
         chk(mem_valid == 1'b1 && mem_addr == ad(10 + k) && mem_data == dt(10 + k),
             "R5 full drain order", 64'(mem_addr), 64'(ad(10 + k)));
         tick();
      end
      chk(mem_valid == 1'b0, "R3 dropped store absent", 64'(mem_valid), 0);
      chk(buf_empty == 1'b1, "R3 empty after full drain", 64'(buf_empty), 1);
      mem_ready = 1'b0;
   endtask

   task automatic t_mismatch_addr;
      lead_put(ad(20), dt(20));
      trail_put(ad(21), dt(20));
      chk(err_flag == 1'b1, "R7 flag on address mismatch", 64'(err_flag), 1);
      chk(err_kind == 2'b01, "R7 kind on address mismatch", 64'(err_kind), 1);
      chk(mem_valid == 1'b0, "R7 mismatched store not released", 64'(mem_valid), 0);
      trail_put(ad(22), dt(22));
      trail_put(ad(23), dt(23));
      chk(err_kind == 2'b01, "R9 first kind kept", 64'(err_kind), 1);
      chk(lead_ready == 1'b0, "R9 enqueue frozen", 64'(lead_ready), 0);
      do_clear();
      chk(err_flag == 1'b0 && err_kind == 2'b00, "R10 error cleared", 64'(err_kind), 0);
      chk(buf_empty == 1'b1 && lead_ready == 1'b1, "R10 buffer emptied", 64'(buf_empty), 1);
   endtask

   task automatic t_mismatch_data_frozen;
      mem_ready = 1'b0;
      lead_put(ad(30), dt(30));
      lead_put(ad(31), dt(31));
      trail_put(ad(30), dt(30));
      chk(mem_valid == 1'b1, "R4 first store checked", 64'(mem_valid), 1);
      trail_put(ad(31), dt(31) ^ 32'h1);
      chk(err_flag == 1'b1 && err_kind == 2'b01, "R7 data mismatch", 64'(err_kind), 1);
      chk(mem_valid == 1'b0, "R9 checked store frozen", 64'(mem_valid), 0);
      mem_ready = 1'b1;
      tick();
      chk(mem_valid == 1'b0, "R9 no drain with ready", 64'(mem_valid), 0);
      mem_ready = 1'b0;
      do_clear();
      chk(mem_valid == 1'b0 && buf_empty == 1'b1, "R10 frozen store discarded", 64'(buf_empty), 1);
   endtask

   task automatic t_underflow;
      trail_put(ad(40), dt(40));
      chk(err_flag == 1'b1 && err_kind == 2'b10, "R8 underflow on empty", 64'(err_kind), 2);
      do_clear();
      mem_ready = 1'b0;
      lead_put(ad(41), dt(41));
      trail_put(ad(41), dt(41));
      chk(err_flag == 1'b0, "R4 matched without error", 64'(err_flag), 0);
      trail_put(ad(41), dt(41));
      chk(err_flag == 1'b1 && err_kind == 2'b10, "R8 underflow with all checked", 64'(err_kind), 2);
      chk(mem_valid == 1'b0, "R9 drain frozen after underflow", 64'(mem_valid), 0);
      do_clear();
   endtask

   task automatic t_after_clear;
      t_reset_state();
      mem_ready = 1'b1;
      lead_put(ad(50), dt(50));
      trail_put(ad(50), dt(50));
      chk(mem_valid == 1'b1 && mem_data == dt(50), "R10 works after clear", 64'(mem_data), 64'(dt(50)));
      tick();
      chk(buf_empty == 1'b1, "R5 drained after clear", 64'(buf_empty), 1);
      mem_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; clr = 1'b0; lead_valid = 1'b0; trail_valid = 1'b0; mem_ready = 1'b0;
      lead_addr = '0; lead_data = '0; trail_addr = '0; trail_data = '0;
      @(negedge clk);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset_state();
      t_hold_then_drain();
      t_full();
      t_mismatch_addr();
      t_mismatch_data_frozen();
      t_underflow();
      t_after_clear();
      summary();
      $finish;
   end

endmodule